// File: doc/BRIEF.md
# FDDI Symbol-Pair Framing Controller

This block takes the received line-symbol stream, one 5-bit code group per clock, and groups it into symbol pairs. It holds a boundary phase and emits a completed pair, with a valid strobe, on every second clock. When a start delimiter (a J symbol followed by a K symbol) appears, the block decides whether the pair boundary may move to it. If it may, the J becomes the first symbol of the emitted pair and a reframe pulse is raised for one clock.

The decision depends on the line state reported by an external detector (Idle, Active or other), on whether the delimiter sits on or off the current boundary, on how long ago the last accepted delimiter began, and on whether an Idle or an ending delimiter has arrived since. Halt pairs (H-H or H-Q) that fall off the boundary while an elasticity buffer is still settling are ignored and flagged. A recenter-done strobe from that buffer releases the hold. The line-state detector, the elasticity buffer, nibble decoding and noise counting are outside the block.

Top module: `fddi_pair_framer`

## Requirements
- R1: Reset sets `phase_o` to 0, keeps every strobe low, releases any halt hold and clears the spacing counter. In the clocks right after reset, the counter reads as if a delimiter had been accepted at the first clock, so in Active state a J-K whose K arrives on the fourth clock after reset is refused.
- R2: A pair completes on the clock whose symbol is the second of a pair. `pair_valid_o` is then high and `pair_o` holds the earlier symbol in bits [9:5] and the current symbol in bits [4:0]. Without a reframe, valid pairs come exactly every second clock.
- R3: The delimiter is J=11000 followed by K=10001. Line state is coded 1=Idle, 2=Active, 0 or 3=other. In Idle state every J-K reframes, whatever its position and spacing. On that K clock `reframe_o` pulses, `pair_valid_o` is high with `pair_o`={J,K}, and `phase_o` takes the new boundary from the next clock.
- R4: In Active state, an on-boundary J-K reframes only if its J starts at least 3 symbol clocks (1.5 byte times) after the J of the previously accepted delimiter. The spacing counter saturates, so a long gap always satisfies the rule.
- R5: In Active state, once a delimiter has been accepted, a later off-boundary J-K is ignored even when the spacing is met, unless R6 applies.
- R6: In Active state, an Idle symbol I=11111 or an ending delimiter T=01101 re-arms framing. The next J-K that meets the spacing rule is then accepted on or off the boundary, and the acceptance uses up the re-arm.
- R7: A J-K arriving while the line state is neither Idle nor Active never reframes.
- R8: A halt pair is H=00100 followed by H or by Q=00000. After any accepted delimiter, an off-boundary halt pair pulses `halt_viol_o` for the one clock in which it completes. A recenter strobe in any line state ends this hold.
- R9: A halt pair arriving with no hold active raises no flag but starts a halt hold. During that hold, off-boundary halt pairs are flagged. A recenter strobe ends it only while the line state is not Active.
- R10: On-boundary halt pairs are never flagged. A halt hold does not stop an Idle-state J-K from reframing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_i | input | 5 | Received code group, one per clock |
| line_state_i | input | 2 | Current line state: 1 Idle, 2 Active, others neither |
| recenter_i | input | 1 | One-clock strobe: elasticity buffer finished recentering |
| pair_o | output | 10 | Earlier symbol in [9:5], later symbol in [4:0] |
| pair_valid_o | output | 1 | `pair_o` holds a completed, aligned pair |
| reframe_o | output | 1 | One-clock pulse: boundary moved to the J-K now emitted |
| phase_o | output | 1 | Symbol-clock parity at which a pair begins |
| halt_viol_o | output | 1 | One-clock pulse: an off-boundary halt pair was ignored |

## Verification
The assertions rely on three properties of the inputs: a new code group arrives on every clock, the line state changes only at clock edges, and the recenter strobe is a single-clock pulse with no tie to symbol position. The spacing and alternation properties also assume that a K can never be the symbol that starts a delimiter. The stimulus drives one symbol per clock on the falling edge, keeps the line state constant across each step, and pulses the recenter strobe alone, so every vector stays within these limits.

// File: rtl/fddi_frm_pkg.sv
package fddi_frm_pkg;

  localparam int SYM_W = 5;
  typedef logic [SYM_W-1:0] sym_t;

  localparam sym_t SYM_J = 5'b11000;
  localparam sym_t SYM_K = 5'b10001;
  localparam sym_t SYM_I = 5'b11111;
  localparam sym_t SYM_T = 5'b01101;
  localparam sym_t SYM_H = 5'b00100;
  localparam sym_t SYM_Q = 5'b00000;

  typedef enum logic [1:0] {
    LS_OTHER  = 2'd0,
    LS_IDLE   = 2'd1,
    LS_ACTIVE = 2'd2,
    LS_SPARE  = 2'd3
  } lstate_e;

  typedef enum logic [1:0] {
    HOLD_FREE = 2'd0,
    HOLD_JK   = 2'd1,
    HOLD_HALT = 2'd2
  } hold_e;

  // start delimiter completes on the current symbol
  function automatic logic is_jk(input sym_t earlier, input sym_t now);
    return (earlier == SYM_J) && (now == SYM_K);
  endfunction

  // halt-halt or halt-quiet completes on the current symbol
  function automatic logic is_halt_pair(input sym_t earlier, input sym_t now);
    return (earlier == SYM_H) && ((now == SYM_H) || (now == SYM_Q));
  endfunction

  // symbols that re-arm reframing while Active
  function automatic logic is_rearm(input sym_t s);
    return (s == SYM_I) || (s == SYM_T);
  endfunction

  // a pair closes when the current parity is the second slot, or on reframe
  function automatic logic closes_pair(input logic par, input logic ph, input logic acc);
    return acc | (par ^ ph);
  endfunction

endpackage

// File: rtl/frm_pair_tracker.sv
module frm_pair_tracker
  import fddi_frm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  sym_t             sym_i,
  input  logic             accept_i,
  output sym_t             prev_sym_o,
  output logic             on_bnd_o,
  output logic             phase_o,
  output logic [2*SYM_W-1:0] pair_o,
  output logic             pair_valid_o
);

  logic par_q;
  logic ph_q;
  sym_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q  <= 1'b0;
      ph_q   <= 1'b0;
      prev_q <= SYM_Q;
    end else begin
      par_q  <= ~par_q;
      prev_q <= sym_i;
      if (accept_i) ph_q <= ~par_q;  // J sat at the previous parity
    end
  end

  assign on_bnd_o     = par_q ^ ph_q;
  assign prev_sym_o   = prev_q;
  assign phase_o      = ph_q;
  assign pair_o       = {prev_q, sym_i};
  assign pair_valid_o = closes_pair(par_q, ph_q, accept_i);

  // R2: a completed pair is never followed by another unless a reframe closes it
  assert_pair_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid_o |=> (!pair_valid_o || accept_i));

  // R3: an accepted delimiter is emitted as the pair J,K
  assert_reframe_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |-> (pair_o == {SYM_J, SYM_K}));

endmodule

// File: rtl/frm_jk_gate.sv
module frm_jk_gate
  import fddi_frm_pkg::*;
#(
  parameter int GAP_W    = 4,
  parameter int HOLD_SYM = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  sym_t    sym_i,
  input  sym_t    prev_sym_i,
  input  lstate_e ls_i,
  input  logic    on_bnd_i,
  output logic    accept_o,
  output logic    arm_o
);

  localparam logic [GAP_W-1:0] GAP_MAX      = '1;
  localparam logic [GAP_W-1:0] GAP_AFTER_JK = GAP_W'(2);

  logic [GAP_W-1:0] gap_q;
  logic             arm_q;
  logic             jk;
  logic             spaced;

  // gap counts clocks since the accepted J; new J distance is gap-1
  function automatic logic spacing_met(input logic [GAP_W-1:0] g);
    return int'(g) > HOLD_SYM;
  endfunction

  function automatic logic [GAP_W-1:0] gap_step(input logic [GAP_W-1:0] g, input logic acc);
    if (acc)            return GAP_AFTER_JK;
    else if (g == GAP_MAX) return g;
    else                return g + 1'b1;
  endfunction

  assign jk     = is_jk(prev_sym_i, sym_i);
  assign spaced = spacing_met(gap_q);

  always_comb begin
    case (ls_i)
      LS_IDLE:   accept_o = jk;
      LS_ACTIVE: accept_o = jk && spaced && (on_bnd_i || arm_q);
      default:   accept_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      arm_q <= 1'b0;
    end else begin
      gap_q <= gap_step(gap_q, accept_o);
      if (accept_o)
        arm_q <= 1'b0;
      else if ((ls_i == LS_ACTIVE) && is_rearm(sym_i))
        arm_q <= 1'b1;
    end
  end

  assign arm_o = arm_q;

  generate
    if (HOLD_SYM >= 2) begin : g_spacing_chk
      // R4: two Active acceptances are never closer than the hold window
      assert_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && (ls_i == LS_ACTIVE)) |-> (!$past(accept_o) && !$past(accept_o, 2)));
    end
  endgenerate

endmodule

// File: rtl/frm_halt_guard.sv
module frm_halt_guard
  import fddi_frm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  sym_t    sym_i,
  input  sym_t    prev_sym_i,
  input  lstate_e ls_i,
  input  logic    on_bnd_i,
  input  logic    recenter_i,
  input  logic    jk_accept_i,
  output logic    viol_o
);

  hold_e hold_q;
  hold_e hold_d;
  logic  halt;

  assign halt   = is_halt_pair(prev_sym_i, sym_i);
  assign viol_o = halt && !on_bnd_i && (hold_q != HOLD_FREE);

  always_comb begin
    hold_d = hold_q;
    case (hold_q)
      HOLD_FREE: if (halt) hold_d = HOLD_HALT;
      HOLD_JK:   if (recenter_i) hold_d = HOLD_FREE;
      HOLD_HALT: if (recenter_i && (ls_i != LS_ACTIVE)) hold_d = HOLD_FREE;
      default:   hold_d = HOLD_FREE;
    endcase
    if (jk_accept_i) hold_d = HOLD_JK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= HOLD_FREE;
    else        hold_q <= hold_d;
  end

  // R8: the violation flag is a single-clock pulse
  assert_viol_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |=> !viol_o);

  // R9: a halt hold survives any clock spent in Active
  assert_halt_hold_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((hold_q == HOLD_HALT) && (ls_i == LS_ACTIVE)) |=> (hold_q != HOLD_FREE));

endmodule

// File: rtl/fddi_pair_framer.sv
module fddi_pair_framer
  import fddi_frm_pkg::*;
#(
  parameter int GAP_W    = 4,
  parameter int HOLD_SYM = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SYM_W-1:0]     sym_i,
  input  logic [1:0]           line_state_i,
  input  logic                 recenter_i,
  output logic [2*SYM_W-1:0]   pair_o,
  output logic                 pair_valid_o,
  output logic                 reframe_o,
  output logic                 phase_o,
  output logic                 halt_viol_o
);

  lstate_e ls;
  sym_t    prev_sym;
  logic    on_bnd;
  logic    accept;
  logic    arm;

  assign ls = lstate_e'(line_state_i);

  frm_pair_tracker u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .sym_i        (sym_i),
    .accept_i     (accept),
    .prev_sym_o   (prev_sym),
    .on_bnd_o     (on_bnd),
    .phase_o      (phase_o),
    .pair_o       (pair_o),
    .pair_valid_o (pair_valid_o)
  );

  frm_jk_gate #(.GAP_W(GAP_W), .HOLD_SYM(HOLD_SYM)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_i      (sym_i),
    .prev_sym_i (prev_sym),
    .ls_i       (ls),
    .on_bnd_i   (on_bnd),
    .accept_o   (accept),
    .arm_o      (arm)
  );

  frm_halt_guard u_halt (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_i       (sym_i),
    .prev_sym_i  (prev_sym),
    .ls_i        (ls),
    .on_bnd_i    (on_bnd),
    .recenter_i  (recenter_i),
    .jk_accept_i (accept),
    .viol_o      (halt_viol_o)
  );

  assign reframe_o = accept;

  // R5: an off-boundary Active reframe needs a re-arm seen since the last one
  assert_offbnd_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reframe_o && (ls == LS_ACTIVE) && !on_bnd) |-> arm);

  // R10: the tracker's boundary and the guard's flag never disagree
  assert_viol_offbnd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_viol_o |-> !on_bnd);

endmodule

// File: tb/fddi_pair_framer_tb.sv
module fddi_pair_framer_tb_top;

  localparam int PERIOD = 10;

  localparam logic [1:0] LO = 2'd0;
  localparam logic [1:0] LI = 2'd1;
  localparam logic [1:0] LA = 2'd2;

  localparam logic [4:0] SJ = 5'b11000;
  localparam logic [4:0] SK = 5'b10001;
  localparam logic [4:0] SI = 5'b11111;
  localparam logic [4:0] ST = 5'b01101;
  localparam logic [4:0] SH = 5'b00100;
  localparam logic [4:0] SQ = 5'b00000;
  localparam logic [4:0] SD = 5'b11110;

  // {req, line state, symbol, recenter, exp valid, exp reframe, exp viol, exp phase}
  localparam int NV = 44;
  localparam logic [15:0] VEC [NV] = '{
    {4'd2,  LI, SD, 1'b0, 4'b0000},
    {4'd2,  LI, SJ, 1'b0, 4'b1000},
    {4'd3,  LI, SK, 1'b0, 4'b1100},  // R3 off-boundary Idle J-K reframes
    {4'd2,  LA, SD, 1'b0, 4'b0001},
    {4'd2,  LA, SD, 1'b0, 4'b1001},
    {4'd4,  LA, SJ, 1'b0, 4'b0001},
    {4'd4,  LA, SK, 1'b0, 4'b1101},  // R4 on-boundary, J four clocks later
    {4'd4,  LA, SJ, 1'b0, 4'b0001},
    {4'd4,  LA, SK, 1'b0, 4'b1001},  // R4 J only two clocks later: refused
    {4'd5,  LA, SD, 1'b0, 4'b0001},
    {4'd5,  LA, SJ, 1'b0, 4'b1001},
    {4'd5,  LA, SK, 1'b0, 4'b0001},  // R5 off-boundary, locked: ignored
    {4'd6,  LA, ST, 1'b0, 4'b1001},
    {4'd6,  LA, SD, 1'b0, 4'b0001},
    {4'd6,  LA, SJ, 1'b0, 4'b1001},
    {4'd6,  LA, SK, 1'b0, 4'b1101},  // R6 re-armed by T: off-boundary accepted
    {4'd2,  LA, SD, 1'b0, 4'b0000},
    {4'd2,  LA, SD, 1'b0, 4'b1000},
    {4'd2,  LA, SD, 1'b0, 4'b0000},
    {4'd2,  LA, SH, 1'b0, 4'b1000},
    {4'd8,  LA, SQ, 1'b0, 4'b0010},  // R8 off-boundary H-Q after J-K
    {4'd10, LA, SD, 1'b0, 4'b1000},
    {4'd10, LA, SH, 1'b0, 4'b0000},
    {4'd10, LA, SH, 1'b0, 4'b1000},  // R10 on-boundary H-H not flagged
    {4'd8,  LA, SD, 1'b1, 4'b0000},  // R8 recenter releases J-K hold
    {4'd9,  LA, SH, 1'b0, 4'b1000},
    {4'd9,  LA, SH, 1'b0, 4'b0000},  // R9 free: no flag, halt hold starts
    {4'd9,  LA, SH, 1'b0, 4'b1000},
    {4'd9,  LA, SQ, 1'b0, 4'b0010},
    {4'd9,  LA, SD, 1'b1, 4'b1000},  // R9 recenter in Active keeps hold
    {4'd9,  LA, SD, 1'b0, 4'b0000},
    {4'd9,  LA, SH, 1'b0, 4'b1000},
    {4'd9,  LA, SQ, 1'b0, 4'b0010},
    {4'd9,  LO, SD, 1'b1, 4'b1000},  // R9 recenter outside Active frees
    {4'd9,  LO, SD, 1'b0, 4'b0000},
    {4'd9,  LO, SH, 1'b0, 4'b1000},
    {4'd9,  LO, SH, 1'b0, 4'b0000},
    {4'd7,  LO, SJ, 1'b0, 4'b1000},
    {4'd7,  LO, SK, 1'b0, 4'b0000},  // R7 other state: no reframe
    {4'd10, LI, SD, 1'b0, 4'b1000},
    {4'd10, LI, SJ, 1'b0, 4'b0000},
    {4'd10, LI, SK, 1'b0, 4'b1100},  // R10 Idle reframes despite halt hold
    {4'd3,  LI, SJ, 1'b0, 4'b0000},
    {4'd3,  LI, SK, 1'b0, 4'b1100}   // R3 Idle ignores spacing
  };

  logic       clk;
  logic       rst_n;
  logic [4:0] sym_i;
  logic [1:0] line_state_i;
  logic       recenter_i;
  logic [9:0] pair_o;
  logic       pair_valid_o;
  logic       reframe_o;
  logic       phase_o;
  logic       halt_viol_o;

  int   checks = 0;
  int   errors = 0;
  logic done   = 1'b0;
  logic [4:0] bprev;

  fddi_pair_framer dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sym_i        (sym_i),
    .line_state_i (line_state_i),
    .recenter_i   (recenter_i),
    .pair_o       (pair_o),
    .pair_valid_o (pair_valid_o),
    .reframe_o    (reframe_o),
    .phase_o      (phase_o),
    .halt_viol_o  (halt_viol_o)
  );

  initial begin
    clk = 1'b0;
    forever #(PERIOD/2) clk = ~clk;
  end

  task automatic check(input logic [9:0] act, input logic [9:0] exp, input int req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // drive one symbol, check the combinational response, move to the next falling edge
  task automatic apply(input logic [1:0] ls, input logic [4:0] s, input logic rc,
                       input logic [3:0] exp, input int req);
    line_state_i = ls;
    sym_i        = s;
    recenter_i   = rc;
    #1;
    check({9'd0, pair_valid_o}, {9'd0, exp[3]}, (req == 3 || req == 6) ? req : 2, "pair_valid");
    if (exp[3]) check(pair_o, {bprev, s}, 2, "pair");
    check({9'd0, reframe_o},   {9'd0, exp[2]}, req, "reframe");
    check({9'd0, halt_viol_o}, {9'd0, exp[1]}, req, "halt_viol");
    check({9'd0, phase_o},     {9'd0, exp[0]}, req, "phase");
    bprev = s;
    @(negedge clk);
  endtask

  // R1: hold reset, check the quiet outputs, release in the low phase
  task automatic do_reset();
    rst_n        = 1'b0;
    sym_i        = SQ;
    line_state_i = LI;
    recenter_i   = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check({9'd0, phase_o},      10'd0, 1, "reset phase");
    check({9'd0, pair_valid_o}, 10'd0, 1, "reset valid");
    check({9'd0, reframe_o},    10'd0, 1, "reset reframe");
    check({9'd0, halt_viol_o},  10'd0, 1, "reset viol");
    bprev = SQ;
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][11:10], VEC[i][9:5], VEC[i][4], VEC[i][3:0], int'(VEC[i][15:12]));
    end

    // R1 spacing counter cleared by reset, then R6 re-arm by I
    do_reset();
    apply(LA, SD, 1'b0, 4'b0000, 1);
    apply(LA, SD, 1'b0, 4'b1000, 2);
    apply(LA, SJ, 1'b0, 4'b0000, 1);
    apply(LA, SK, 1'b0, 4'b1000, 1);   // R1 too soon after reset
    apply(LA, SI, 1'b0, 4'b0000, 6);
    apply(LA, SJ, 1'b0, 4'b1000, 6);
    apply(LA, SK, 1'b0, 4'b1100, 6);   // R6 off-boundary after I
    apply(LA, SD, 1'b0, 4'b0001, 3);   // R3 phase follows the new boundary

    // R1 halt hold cleared by reset, then R9 hold starts
    do_reset();
    apply(LA, SD, 1'b0, 4'b0000, 1);
    apply(LA, SH, 1'b0, 4'b1000, 1);
    apply(LA, SQ, 1'b0, 4'b0000, 1);   // R1 no hold after reset
    apply(LA, SD, 1'b0, 4'b1000, 9);
    apply(LA, SD, 1'b0, 4'b0000, 9);
    apply(LA, SH, 1'b0, 4'b1000, 9);
    apply(LA, SQ, 1'b0, 4'b0010, 9);   // R9 flagged under halt hold

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule